// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a memory-mapped timer with a parameterised number of independent channels (two by default). Each channel holds a down-counter, a reload interval and a control word. It picks one of two clock-enable inputs as its time base and divides that source by a power of two. When a channel's count runs out, it raises a pending flag in a shared status register. The interrupt output is asserted while any pending flag is set and that channel's interrupt is enabled.

Software programs the block through a plain word-wide register port (address, write strobe, write data, combinational read data). A channel either runs periodically, reloading from its interval on every expiry, or fires once and then stops by clearing its own enable bit. The interval can be copied into the counter with a self-clearing control bit, and the counter can also be written directly.

Top module: `multi_timer`

## Requirements
- R1: After reset every register reads zero, all channels are stopped and `irq` is low.
- R2: Address 0x00 holds the interrupt-enable bits, where bit n belongs to channel n. Address 0x04 holds the pending bits. Channel n decodes at base 0x10 + 0x10*n, with control at +0x0, interval at +0x4 and count at +0x8. The interval register reads back as written. Enable bits above the channel count read zero. Every other address, unaligned ones included, reads zero.
- R3: While enabled, a channel's count drops by one on each prescaled tick. It holds when the channel is disabled or its source gives no enable.
- R4: Control bits 6:4 hold a prescaler code k that divides the selected source by 2^k. After a control write, the first tick falls on the 2^k-th enabled source cycle.
- R5: Control bits 3:2 select the source: 0 selects `clk_en_lo`, 1 selects `clk_en_hi`, and 2 or 3 gives no ticks at all.
- R6: Control bit 7 clear selects periodic mode. A tick that finds the count at 1 or 0 sets the channel's pending bit, reloads the count from the interval and leaves the channel running.
- R7: Control bit 7 set selects single-shot mode. The expiring tick sets the pending bit, leaves the count at 0 and clears control bit 0 (enable). The count then stays at 0.
- R8: Writing control with bit 1 set copies the interval into the count at that clock edge. Bit 1 always reads 0.
- R9: A write to the count register loads the written value. The write takes precedence over a tick in the same cycle.
- R10: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R11: `irq` is high exactly when some channel has both its pending bit and its enable bit set. The enable bits do not stop pending bits from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| clk_en_lo | input | 1 | Low-speed source enable (source code 0) |
| clk_en_hi | input | 1 | High-speed source enable (source code 1) |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives several edge cases directly:
- Expiry from counts of both 1 and 0. A design that waited for one extra tick would report every period one tick late.
- A prescaled tick colliding with a count write or a reload request. A design that let the tick win would load a value one below what software wrote.
- Prescaler phase after a control write. A design that kept the old phase would fire its first tick early.
- The unused source codes. A design that mapped them onto a real source would count when it should stay frozen.

Random traffic from a fixed seed also produces pending-bit clears that land on the same cycle as an expiry. A design in which the clear won would lose interrupts. The model also checks that a single-shot channel ends with its enable bit read back as zero.

// File: rtl/mtmr_pkg.sv
`timescale 1ns/1ps
package mtmr_pkg;

    // control word bit positions (shared by decode and readback)
    localparam int CTL_EN_B    = 0;
    localparam int CTL_RLD_B   = 1;
    localparam int CTL_SRC_LSB = 2;
    localparam int CTL_PSC_LSB = 4;
    localparam int CTL_OS_B    = 7;
    localparam int CTL_W       = 8;

    localparam logic [1:0] SRC_LO = 2'd0;
    localparam logic [1:0] SRC_HI = 2'd1;

    typedef struct packed {
        logic       oneshot;
        logic [2:0] psc;
        logic [1:0] src;
        logic       en;
    } ctl_t;

    function automatic ctl_t ctl_unpack(input logic [CTL_W-1:0] w);
        ctl_t c;
        c.en      = w[CTL_EN_B];
        c.src     = w[CTL_PSC_LSB-1:CTL_SRC_LSB];
        c.psc     = w[CTL_OS_B-1:CTL_PSC_LSB];
        c.oneshot = w[CTL_OS_B];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c);
        logic [CTL_W-1:0] w;
        w = '0;
        w[CTL_EN_B]                   = c.en;
        w[CTL_PSC_LSB-1:CTL_SRC_LSB]  = c.src;
        w[CTL_OS_B-1:CTL_PSC_LSB]     = c.psc;
        w[CTL_OS_B]                   = c.oneshot;
        return w;
    endfunction

endpackage

// File: rtl/mtmr_prescale.sv
`timescale 1ns/1ps
module mtmr_prescale #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [1:0]       src_sel,
    input  logic [PSC_W-1:0] code,
    input  logic             src_lo,
    input  logic             src_hi,
    output logic             tick
);
    import mtmr_pkg::*;

    localparam int DIV_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } psc_st_t;

    psc_st_t st_d, st_q;
    logic             src_on;
    logic [DIV_W-1:0] mask;

    always_comb begin
        st_d   = st_q;
        unique case (src_sel)
            SRC_LO:  src_on = src_lo;
            SRC_HI:  src_on = src_hi;
            default: src_on = 1'b0;
        endcase
        mask = ~({DIV_W{1'b1}} << code);
        tick = run && src_on && ((st_q.div & mask) == mask);
        if (!run || restart) begin
            st_d.div = '0;
        end else if (src_on) begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: unused source codes never produce a tick
    p_no_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel[1] |-> !tick);
    // R4: a stopped or just restarted divider starts its phase from zero
    p_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart || !run) |=> st_q.div == '0);
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

endmodule

// File: rtl/mtmr_channel.sv
`timescale 1ns/1ps
module mtmr_channel #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_lo,
    input  logic              src_hi,
    input  logic              wr_ctl,
    input  logic              wr_intv,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_rd,
    output logic [DATA_W-1:0] intv_rd,
    output logic [DATA_W-1:0] cnt_rd,
    output logic              expire
);
    import mtmr_pkg::*;

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] intv;
        logic [CNT_W-1:0] cnt;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   tick;

    mtmr_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.ctl.en),
        .restart (wr_ctl),
        .src_sel (st_q.ctl.src),
        .code    (st_q.ctl.psc),
        .src_lo  (src_lo),
        .src_hi  (src_hi),
        .tick    (tick)
    );

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (wr_intv) begin
            st_d.intv = wdata[CNT_W-1:0];
        end
        if (wr_ctl) begin
            st_d.ctl = ctl_unpack(wdata[CTL_W-1:0]);
            if (wdata[CTL_RLD_B]) begin
                st_d.cnt = st_q.intv;
            end
        end else if (wr_cnt) begin
            st_d.cnt = wdata[CNT_W-1:0];
        end else if (tick) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                expire = 1'b1;
                if (st_q.ctl.oneshot) begin
                    st_d.cnt    = '0;
                    st_d.ctl.en = 1'b0;
                end else begin
                    st_d.cnt = st_q.intv;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_rd  = DATA_W'(ctl_pack(st_q.ctl));
    assign intv_rd = DATA_W'(st_q.intv);
    assign cnt_rd  = DATA_W'(st_q.cnt);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_ctl && !wr_cnt) |=> $stable(st_q.cnt));
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_ctl && !wr_cnt && st_q.cnt > CNT_W'(1))
        |=> st_q.cnt == $past(st_q.cnt) - 1'b1);
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_ctl && !wr_cnt && st_q.cnt <= CNT_W'(1) && !st_q.ctl.oneshot)
        |=> (st_q.cnt == $past(st_q.intv)) && st_q.ctl.en);
    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_ctl && !wr_cnt && st_q.cnt <= CNT_W'(1) && st_q.ctl.oneshot)
        |=> (st_q.cnt == '0) && !st_q.ctl.en);
    p_arl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[CTL_RLD_B]) |=> st_q.cnt == $past(st_q.intv));
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && !wr_ctl) |=> st_q.cnt == $past(wdata[CNT_W-1:0]));

endmodule

// File: rtl/mtmr_irq.sv
`timescale 1ns/1ps
module mtmr_irq #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ie,
    input  logic              wr_sts,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] ie_rd,
    output logic [NUM_CH-1:0] sts_rd,
    output logic              irq
);
    typedef struct packed {
        logic [NUM_CH-1:0] ie;
        logic [NUM_CH-1:0] sts;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ie) begin
            st_d.ie = wdata;
        end
        if (wr_sts) begin
            st_d.sts = st_q.sts & ~wdata;
        end
        st_d.sts = st_d.sts | expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ie_rd  = st_q.ie;
    assign sts_rd = st_q.sts;
    assign irq    = |(st_q.sts & st_q.ie);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |=> st_q.sts[i]);
        p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sts && wdata[i] && !expire[i]) |=> !st_q.sts[i]);
        p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.sts[i] && !(wr_sts && wdata[i])) |=> st_q.sts[i]);
    end

    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.sts != '0));

endmodule

// File: rtl/multi_timer.sv
`timescale 1ns/1ps
module multi_timer #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              clk_en_lo,
    input  logic              clk_en_hi,
    output logic              irq
);
    localparam int OFF_IE    = 'h00;
    localparam int OFF_STS   = 'h04;
    localparam int CH_BASE   = 'h10;
    localparam int CH_STRIDE = 'h10;
    localparam int OFF_CTL   = 'h0;
    localparam int OFF_INTV  = 'h4;
    localparam int OFF_CNT   = 'h8;

    logic [NUM_CH-1:0] expire;
    logic [NUM_CH-1:0] ie_rd, sts_rd;
    logic [DATA_W-1:0] ctl_rd  [NUM_CH];
    logic [DATA_W-1:0] intv_rd [NUM_CH];
    logic [DATA_W-1:0] cnt_rd  [NUM_CH];
    logic              wr_ie, wr_sts;

    assign wr_ie  = bus_we && (bus_addr == ADDR_W'(OFF_IE));
    assign wr_sts = bus_we && (bus_addr == ADDR_W'(OFF_STS));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * c;
        logic wr_ctl, wr_intv, wr_cnt;
        assign wr_ctl  = bus_we && (bus_addr == ADDR_W'(BASE + OFF_CTL));
        assign wr_intv = bus_we && (bus_addr == ADDR_W'(BASE + OFF_INTV));
        assign wr_cnt  = bus_we && (bus_addr == ADDR_W'(BASE + OFF_CNT));

        mtmr_channel #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W),
            .PSC_W  (PSC_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_lo  (clk_en_lo),
            .src_hi  (clk_en_hi),
            .wr_ctl  (wr_ctl),
            .wr_intv (wr_intv),
            .wr_cnt  (wr_cnt),
            .wdata   (bus_wdata),
            .ctl_rd  (ctl_rd[c]),
            .intv_rd (intv_rd[c]),
            .cnt_rd  (cnt_rd[c]),
            .expire  (expire[c])
        );
    end

    mtmr_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ie  (wr_ie),
        .wr_sts (wr_sts),
        .wdata  (bus_wdata[NUM_CH-1:0]),
        .expire (expire),
        .ie_rd  (ie_rd),
        .sts_rd (sts_rd),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_IE))  bus_rdata = DATA_W'(ie_rd);
        if (bus_addr == ADDR_W'(OFF_STS)) bus_rdata = DATA_W'(sts_rd);
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_CTL))  bus_rdata = ctl_rd[c];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_INTV)) bus_rdata = intv_rd[c];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_CNT))  bus_rdata = cnt_rd[c];
        end
    end

    // R1: nothing can request an interrupt straight out of reset
    p_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !irq);

endmodule

// File: tb/sim_multi_timer.sv
`timescale 1ns/1ps
module sim_multi_timer;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        clk_lo = 1'b0;
    logic        clk_hi = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    logic        chk_on = 1'b0;
    int          n_chk = 0;
    int          n_err = 0;

    always #5 clk = ~clk;

    multi_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .clk_en_lo (clk_lo),
        .clk_en_hi (clk_hi),
        .irq       (irq)
    );

    // ---------------- reference model, built from the requirements ----------
    logic        m_en   [NCH];
    logic [1:0]  m_src  [NCH];
    logic [2:0]  m_psc  [NCH];
    logic        m_os   [NCH];
    logic [31:0] m_intv [NCH];
    logic [31:0] m_cnt  [NCH];
    logic [6:0]  m_div  [NCH];
    logic [1:0]  m_ie, m_sts;

    task automatic m_reset();
        for (int c = 0; c < NCH; c++) begin
            m_en[c] = 0; m_src[c] = 0; m_psc[c] = 0; m_os[c] = 0;
            m_intv[c] = 0; m_cnt[c] = 0; m_div[c] = 0;
        end
        m_ie = 0; m_sts = 0;
    endtask

    task automatic m_step();
        logic [1:0] nsts;
        nsts = m_sts;
        if (we && addr == 8'h04) nsts = nsts & ~wdata[1:0];
        for (int c = 0; c < NCH; c++) begin
            logic wc, wi, wv, on, tk;
            logic [6:0] msk;
            wc  = we && addr == 8'(16 + 16 * c);
            wi  = we && addr == 8'(20 + 16 * c);
            wv  = we && addr == 8'(24 + 16 * c);
            on  = (m_src[c] == 0) ? clk_lo : (m_src[c] == 1) ? clk_hi : 1'b0;
            msk = 7'((1 << m_psc[c]) - 1);
            tk  = m_en[c] && on && ((m_div[c] & msk) == msk);
            if (!m_en[c] || wc) m_div[c] = 0;
            else if (on)        m_div[c] = m_div[c] + 1;
            if (wc) begin
                m_en[c] = wdata[0]; m_src[c] = wdata[3:2];
                m_psc[c] = wdata[6:4]; m_os[c] = wdata[7];
                if (wdata[1]) m_cnt[c] = m_intv[c];
            end else if (wv) begin
                m_cnt[c] = wdata;
            end else if (tk) begin
                if (m_cnt[c] <= 1) begin
                    nsts[c] = 1'b1;
                    if (m_os[c]) begin m_cnt[c] = 0; m_en[c] = 0; end
                    else m_cnt[c] = m_intv[c];
                end else m_cnt[c] = m_cnt[c] - 1;
            end
            if (wi) m_intv[c] = wdata;
        end
        if (we && addr == 8'h00) m_ie = wdata[1:0];
        m_sts = nsts;
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return {30'b0, m_ie};
        if (a == 8'h04) return {30'b0, m_sts};
        for (int c = 0; c < NCH; c++) begin
            if (a == 8'(16 + 16 * c)) return {24'b0, m_os[c], m_psc[c], m_src[c], 1'b0, m_en[c]};
            if (a == 8'(20 + 16 * c)) return m_intv[c];
            if (a == 8'(24 + 16 * c)) return m_cnt[c];
        end
        return 32'h0;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h04) return "R10";
        if (a == 8'h10 || a == 8'h20) return "R7";
        if (a == 8'h18 || a == 8'h28) return "R3";
        return "R2";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else        m_step();
    end

    // ---------------- checking ----------------------------------------------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // compare every cycle against the model, away from the clock edge
    always @(negedge clk) begin
        if (chk_on) begin
            check(tag_of(addr), rdata, m_read(addr));
            check("R11", {31'b0, irq}, {31'b0, |(m_sts & m_ie)});
        end
    end

    task automatic check_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a; #1;
        check(tag, rdata, exp);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk); #1;
        we = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        chk_on = 1'b1;
        #1;
        // R1: everything reads zero after reset
        for (int a = 0; a < 64; a += 4) check_rd(8'(a), 32'h0, "R1");
        check("R1", {31'b0, irq}, 32'h0);

        // R2: map, masking and unused addresses
        bus_write(8'h00, 32'hFFFF_FFFF);
        check_rd(8'h00, 32'h3, "R2");
        bus_write(8'h24, 32'hDEAD_BEEF);
        check_rd(8'h24, 32'hDEAD_BEEF, "R2");
        check_rd(8'h3C, 32'h0, "R2");
        check_rd(8'h01, 32'h0, "R2");
        bus_write(8'h00, 32'h0);

        // R4: divide by 4 on the high source
        clk_hi = 1'b1; clk_lo = 1'b0;
        bus_write(8'h18, 32'd100);
        bus_write(8'h10, 32'h25);
        addr = 8'h18;
        wait_edges(3); check_rd(8'h18, 32'd100, "R4");
        wait_edges(1); check_rd(8'h18, 32'd99, "R4");
        wait_edges(4); check_rd(8'h18, 32'd98, "R4");

        // R6 / R11 / R10: periodic expiry and pending bit handling
        bus_write(8'h10, 32'h0);
        bus_write(8'h04, 32'h3);
        bus_write(8'h14, 32'd3);
        bus_write(8'h18, 32'd3);
        bus_write(8'h00, 32'h1);
        bus_write(8'h10, 32'h05);
        wait_edges(3);
        check_rd(8'h04, 32'h1, "R6");
        check_rd(8'h18, 32'd3, "R6");
        check("R11", {31'b0, irq}, 32'h1);
        bus_write(8'h00, 32'h0);
        check("R11", {31'b0, irq}, 32'h0);
        check_rd(8'h04, 32'h1, "R11");
        bus_write(8'h10, 32'h0);
        bus_write(8'h04, 32'h2);
        check_rd(8'h04, 32'h1, "R10");
        bus_write(8'h04, 32'h1);
        check_rd(8'h04, 32'h0, "R10");

        // R7: single shot on channel 1
        bus_write(8'h28, 32'd2);
        bus_write(8'h20, 32'h85);
        wait_edges(2);
        check_rd(8'h20, 32'h84, "R7");
        check_rd(8'h28, 32'd0, "R7");
        check_rd(8'h04, 32'h2, "R7");
        wait_edges(5);
        check_rd(8'h28, 32'd0, "R7");

        // R9: direct count write while running
        bus_write(8'h18, 32'd1000);
        bus_write(8'h10, 32'h05);
        wait_edges(4);
        bus_write(8'h18, 32'd500);
        check_rd(8'h18, 32'd500, "R9");
        wait_edges(1);
        check_rd(8'h18, 32'd499, "R9");

        // R8: reload request copies interval, bit reads back zero
        bus_write(8'h10, 32'h0);
        bus_write(8'h14, 32'd77);
        bus_write(8'h10, 32'h02);
        check_rd(8'h18, 32'd77, "R8");
        check_rd(8'h10, 32'h0, "R8");

        // R5: source selection
        bus_write(8'h28, 32'd50);
        clk_lo = 1'b1; clk_hi = 1'b1;
        bus_write(8'h20, 32'h09);
        wait_edges(10);
        check_rd(8'h28, 32'd50, "R5");
        clk_lo = 1'b0;
        bus_write(8'h20, 32'h01);
        wait_edges(4);
        check_rd(8'h28, 32'd50, "R5");
        clk_lo = 1'b1;
        wait_edges(3);
        check_rd(8'h28, 32'd47, "R5");

        // constrained random traffic, checked every cycle against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] d;
            logic [3:0]  pick;
            @(negedge clk); #1;
            clk_lo = ($urandom % 3) == 0;
            clk_hi = ($urandom % 4) != 0;
            pick = 4'($urandom % 12);
            case (pick)
                0: addr = 8'h00;  1: addr = 8'h04;
                2: addr = 8'h10;  3: addr = 8'h14;  4: addr = 8'h18;
                5: addr = 8'h20;  6: addr = 8'h24;  7: addr = 8'h28;
                8: addr = 8'h18;  9: addr = 8'h28;  10: addr = 8'h04;
                default: addr = 8'($urandom);
            endcase
            we = ($urandom % 10) < 3;
            d = $urandom;
            if (addr == 8'h10 || addr == 8'h20) begin
                d[0]   = ($urandom % 4) != 0;
                d[1]   = ($urandom % 4) == 0;
                d[3:2] = (($urandom % 8) == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
                d[6:4] = 3'($urandom % 4);
                d[7]   = ($urandom % 3) == 0;
            end else if (addr == 8'h14 || addr == 8'h18 || addr == 8'h24 || addr == 8'h28) begin
                d = $urandom % 41;
            end
            wdata = d;
        end
        @(negedge clk); #1;
        we = 1'b0;
        wait_edges(2);
        chk_on = 1'b0;
        finish_run();
    end

endmodule